// File: doc/BRIEF.md
# Shuffle-Exchange Message Router

This block moves 64 four-bit messages between a memory and a bank of message processors. The lanes pass through a cascade of perfect-shuffle stages, and each stage ends in a row of two-by-two switches. The routing is set by a stored control word, so the same hardware can apply any permutation that the offline tool has reduced to switch settings. The forward path applies the interleaving. The backward path runs the same settings in reverse and applies the inverse permutation. A message sent forward and then sent back with the same word therefore returns to its original lane.

The control store holds 96 words of 192 bits each, one for every permutation the decoding schedule needs. A programming agent loads the words through a write port before decoding starts. During decoding, the controller pulses `sel_load` with the index of the next permutation. The chosen word is latched into an active register. From the next cycle, both data paths route combinationally from that register until another word is loaded.

Top module: `shuffle_router`

## Requirements
- R1: Both data buses carry 64 lanes of 4 bits, with lane j at bits [4j+3:4j]. Each output holds exactly the input messages, rearranged.
- R2: The forward path runs stage 0 first and stage 5 last. Each stage first moves the message in lane i to lane ((i<<1)|(i>>5)) mod 64. It then uses switch k to act on lanes 2k and 2k+1, controlled by bit 32s+k of the active word. A bit of 0 passes the two lanes straight and a bit of 1 swaps them.
- R3: The backward path runs stage 5 first and stage 0 last. Each stage applies the switch row first and then the inverse shuffle. Routing data forward and then backward with the same word returns the original bus.
- R4: When `cfg_we` is high at a rising edge and `cfg_waddr` is below 96, `cfg_wdata` is stored at that address.
- R5: A write to an address of 96 or more changes no stored word.
- R6: When `sel_load` is high at a rising edge, the word at `sel_addr` becomes the active word, and it governs routing from that edge onward. While `sel_load` is low, the active word does not change.
- R7: A load with `sel_addr` of 96 or more leaves the active word unchanged.
- R8: If a write and a load name the same address at the same edge, the load takes the word that was stored before the write.
- R9: Reset clears the active word to all zeros. With all switches straight, six shuffles compose to the identity, so `fwd_out` equals `fwd_in` and `bwd_out` equals `bwd_in`.
- R10: Routing has no register on the data path. A change on `fwd_in` or `bwd_in` appears on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-store write strobe |
| cfg_waddr | input | 7 | Control-store write index |
| cfg_wdata | input | 192 | Switch settings, stage s in bits [32s+31:32s] |
| sel_load | input | 1 | Latch the word at sel_addr as active |
| sel_addr | input | 7 | Index of the permutation to apply |
| fwd_in | input | 256 | Messages entering the interleaving path |
| fwd_out | output | 256 | Interleaved messages |
| bwd_in | input | 256 | Messages entering the de-interleaving path |
| bwd_out | output | 256 | De-interleaved messages |

## Verification
Writes and loads take effect at the single rising edge that samples them. A stored word becomes visible on the data paths only after a load edge that follows its write edge. The data paths themselves have zero latency. The bench drives every input just after a falling edge. It checks routed outputs 1 ns after changing the data, well before the next rising edge, so each result is read in the half-cycle in which it is due. The active word is checked through the forward and backward outputs, which the bench compares against its own lane-tracing model.

// File: rtl/router_pkg.sv
package router_pkg;

  // Rotate a w-bit lane index left by one: the perfect shuffle.
  function automatic int rot_left(input int v, input int w);
    int m;
    m = (1 << w) - 1;
    return ((v << 1) | (v >> (w - 1))) & m;
  endfunction

  // Rotate a w-bit lane index right by one: the inverse shuffle.
  function automatic int rot_right(input int v, input int w);
    int m;
    m = (1 << w) - 1;
    return ((v >> 1) | ((v & 1) << (w - 1))) & m;
  endfunction

endpackage

// File: rtl/se_cfg_store.sv
module se_cfg_store #(
  parameter int NUM_CFG = 96,
  parameter int CFG_W   = 192,
  parameter int CFG_AW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              ld_en,
  input  logic [CFG_AW-1:0] ld_addr,
  output logic [CFG_W-1:0]  active_word,
  output logic              wr_ok,
  output logic              ld_ok
);

  logic [CFG_W-1:0] mem [NUM_CFG];

  // Requests naming an index past the last stored word are dropped.
  assign wr_ok = wr_en && (int'(wr_addr) < NUM_CFG);
  assign ld_ok = ld_en && (int'(ld_addr) < NUM_CFG);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  // The active register reads the array before the same-edge write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_word <= '0;
    else if (ld_ok) active_word <= mem[ld_addr];
  end

endmodule

// File: rtl/se_fwd_stage.sv
module se_fwd_stage #(
  parameter int LANES = 64,
  parameter int MSG_W = 4,
  parameter int IDX_W = 6
) (
  input  logic [LANES*MSG_W-1:0] in_bus,
  input  logic [LANES/2-1:0]     ctl,
  output logic [LANES*MSG_W-1:0] out_bus
);

  logic [MSG_W-1:0] sh [LANES];

  // Perfect shuffle: lane j receives the message from lane rot_right(j).
  for (genvar j = 0; j < LANES; j++) begin : g_shuf
    localparam int SRC = router_pkg::rot_right(j, IDX_W);
    assign sh[j] = in_bus[SRC*MSG_W +: MSG_W];
  end

  // Switch row: bit k set swaps lanes 2k and 2k+1.
  for (genvar k = 0; k < LANES/2; k++) begin : g_sw
    assign out_bus[(2*k)*MSG_W +: MSG_W]   = ctl[k] ? sh[2*k+1] : sh[2*k];
    assign out_bus[(2*k+1)*MSG_W +: MSG_W] = ctl[k] ? sh[2*k]   : sh[2*k+1];
  end

endmodule

// File: rtl/se_bwd_stage.sv
module se_bwd_stage #(
  parameter int LANES = 64,
  parameter int MSG_W = 4,
  parameter int IDX_W = 6
) (
  input  logic [LANES*MSG_W-1:0] in_bus,
  input  logic [LANES/2-1:0]     ctl,
  output logic [LANES*MSG_W-1:0] out_bus
);

  logic [MSG_W-1:0] sw [LANES];

  // The switch row is its own inverse, so it comes first here.
  for (genvar k = 0; k < LANES/2; k++) begin : g_sw
    assign sw[2*k]   = ctl[k] ? in_bus[(2*k+1)*MSG_W +: MSG_W] : in_bus[(2*k)*MSG_W +: MSG_W];
    assign sw[2*k+1] = ctl[k] ? in_bus[(2*k)*MSG_W +: MSG_W]   : in_bus[(2*k+1)*MSG_W +: MSG_W];
  end

  // Inverse shuffle: lane j takes the message sitting at rot_left(j).
  for (genvar j = 0; j < LANES; j++) begin : g_unshuf
    localparam int SRC = router_pkg::rot_left(j, IDX_W);
    assign out_bus[j*MSG_W +: MSG_W] = sw[SRC];
  end

endmodule

// File: rtl/shuffle_router.sv
module shuffle_router #(
  parameter int LANES   = 64,
  parameter int MSG_W   = 4,
  parameter int NUM_CFG = 96,
  localparam int STAGES = $clog2(LANES),
  localparam int SW_PER = LANES / 2,
  localparam int CFG_W  = STAGES * SW_PER,
  localparam int CFG_AW = $clog2(NUM_CFG),
  localparam int BUS_W  = LANES * MSG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              sel_load,
  input  logic [CFG_AW-1:0] sel_addr,
  input  logic [BUS_W-1:0]  fwd_in,
  output logic [BUS_W-1:0]  fwd_out,
  input  logic [BUS_W-1:0]  bwd_in,
  output logic [BUS_W-1:0]  bwd_out
);

  logic [CFG_W-1:0] active_word;
  logic             wr_ok;
  logic             ld_ok;

  se_cfg_store #(
    .NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .CFG_AW(CFG_AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .ld_en(sel_load), .ld_addr(sel_addr),
    .active_word(active_word), .wr_ok(wr_ok), .ld_ok(ld_ok)
  );

  logic [BUS_W-1:0] fwd_lv [STAGES+1];
  logic [BUS_W-1:0] bwd_lv [STAGES+1];

  assign fwd_lv[0]      = fwd_in;
  assign fwd_out        = fwd_lv[STAGES];
  assign bwd_lv[STAGES] = bwd_in;
  assign bwd_out        = bwd_lv[0];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    // Forward goes from level s to s+1 and backward from s+1 to s, both with stage s bits.
    se_fwd_stage #(.LANES(LANES), .MSG_W(MSG_W), .IDX_W(STAGES)) u_fwd (
      .in_bus(fwd_lv[s]), .ctl(active_word[s*SW_PER +: SW_PER]), .out_bus(fwd_lv[s+1])
    );
    se_bwd_stage #(.LANES(LANES), .MSG_W(MSG_W), .IDX_W(STAGES)) u_bwd (
      .in_bus(bwd_lv[s+1]), .ctl(active_word[s*SW_PER +: SW_PER]), .out_bus(bwd_lv[s])
    );
  end

endmodule

// File: rtl/shuffle_router_chk.sv
module shuffle_router_chk #(
  parameter int LANES   = 64,
  parameter int MSG_W   = 4,
  parameter int NUM_CFG = 96,
  localparam int CFG_W  = $clog2(LANES) * (LANES / 2),
  localparam int CFG_AW = $clog2(NUM_CFG),
  localparam int BUS_W  = LANES * MSG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_waddr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic              sel_load,
  input logic [CFG_AW-1:0] sel_addr,
  input logic [CFG_W-1:0]  active_word,
  input logic [BUS_W-1:0]  fwd_in,
  input logic [BUS_W-1:0]  fwd_out,
  input logic [BUS_W-1:0]  bwd_in,
  input logic [BUS_W-1:0]  bwd_out
);

  assert_fwd_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fwd_out) == $countones(fwd_in));

  assert_bwd_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bwd_out) == $countones(bwd_in));

  assert_round_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_in == fwd_out) |-> (bwd_out == fwd_in));

  assert_write_then_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_waddr) < NUM_CFG) ##1
    (sel_load && sel_addr == $past(cfg_waddr) && !(cfg_we && cfg_waddr == sel_addr))
    |=> (active_word == $past(cfg_wdata, 2)));

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> $stable(active_word));

  assert_bad_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && int'(sel_addr) >= NUM_CFG) |=> $stable(active_word));

endmodule

bind shuffle_router shuffle_router_chk #(
  .LANES(LANES), .MSG_W(MSG_W), .NUM_CFG(NUM_CFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
  .cfg_wdata(cfg_wdata), .sel_load(sel_load), .sel_addr(sel_addr),
  .active_word(active_word), .fwd_in(fwd_in), .fwd_out(fwd_out),
  .bwd_in(bwd_in), .bwd_out(bwd_out)
);

// File: tb/shuffle_router_bench.sv
module shuffle_router_bench;

  localparam int LANES = 64;
  localparam int MSG_W = 4;
  localparam int NCFG  = 96;
  localparam int NST   = 6;
  localparam int CW    = 192;
  localparam int BW    = 256;

  // Table entry: {address, word seed, data seed}.
  localparam logic [70:0] VEC [6] = '{
    {7'd0,  32'h0000_0000, 32'h1357_9BDF},
    {7'd95, 32'hFFFF_FFFF, 32'h2468_ACE0},
    {7'd1,  32'hDEAD_BEEF, 32'h0BAD_F00D},
    {7'd47, 32'h1234_5678, 32'hCAFE_0001},
    {7'd63, 32'h0F0F_A5A5, 32'h7777_3333},
    {7'd17, 32'h8000_0001, 32'h5A5A_C3C3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_waddr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic sel_load = 1'b0;
  logic [6:0] sel_addr = '0;
  logic [BW-1:0] fwd_in = '0;
  logic [BW-1:0] bwd_in = '0;
  logic [BW-1:0] fwd_out;
  logic [BW-1:0] bwd_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  shuffle_router u_shuffle_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .sel_load(sel_load), .sel_addr(sel_addr),
    .fwd_in(fwd_in), .fwd_out(fwd_out), .bwd_in(bwd_in), .bwd_out(bwd_out)
  );

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [CW-1:0] gen_word(input logic [31:0] seed);
    logic [CW-1:0] w;
    logic [31:0] x;
    if (seed == 32'h0) return '0;
    if (seed == 32'hFFFF_FFFF) return '1;
    x = seed;
    for (int i = 0; i < NST; i++) begin
      x = xs(x);
      w[i*32 +: 32] = x;
    end
    return w;
  endfunction

  function automatic logic [BW-1:0] gen_data(input logic [31:0] seed);
    logic [BW-1:0] d;
    logic [31:0] x;
    x = seed | 32'h1;
    for (int i = 0; i < 8; i++) begin
      x = xs(x);
      d[i*32 +: 32] = x;
    end
    return d;
  endfunction

  // Follow one source lane through all stages to its final lane.
  function automatic int dest_lane(input logic [CW-1:0] w, input int src);
    int p;
    p = src;
    for (int s = 0; s < NST; s++) begin
      p = ((p << 1) | (p >> 5)) & 63;
      if (w[32*s + (p >> 1)]) p = p ^ 1;
    end
    return p;
  endfunction

  function automatic logic [BW-1:0] fwd_model(input logic [CW-1:0] w, input logic [BW-1:0] d);
    logic [BW-1:0] o;
    o = '0;
    for (int i = 0; i < LANES; i++) o[dest_lane(w, i)*MSG_W +: MSG_W] = d[i*MSG_W +: MSG_W];
    return o;
  endfunction

  function automatic logic [BW-1:0] bwd_model(input logic [CW-1:0] w, input logic [BW-1:0] d);
    logic [BW-1:0] o;
    o = '0;
    for (int i = 0; i < LANES; i++) o[i*MSG_W +: MSG_W] = d[dest_lane(w, i)*MSG_W +: MSG_W];
    return o;
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [6:0] a, input logic [CW-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cfg(input logic [6:0] a);
    @(negedge clk);
    sel_load = 1'b1; sel_addr = a;
    @(negedge clk);
    sel_load = 1'b0;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] w;
    logic [CW-1:0] wa;
    logic [CW-1:0] wb;
    logic [BW-1:0] d;
    logic [BW-1:0] e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: after reset the active word is all straight, so both paths pass data through.
    d = gen_data(32'h0000_ABCD);
    fwd_in = d; bwd_in = ~d;
    #1;
    check("R9 fwd identity after reset", fwd_out, d);
    check("R9 bwd identity after reset", bwd_out, ~d);

    // Table walk: store, load, route forward, round trip, route backward.
    for (int v = 0; v < 6; v++) begin
      w = gen_word(VEC[v][63:32]);
      d = gen_data(VEC[v][31:0]);
      write_cfg(VEC[v][70:64], w);
      load_cfg(VEC[v][70:64]);
      fwd_in = d;
      #1;
      e = fwd_model(w, d);
      check("R2 R4 R6 forward route", fwd_out, e);
      bwd_in = fwd_out;
      #1;
      check("R3 round trip", bwd_out, d);
      bwd_in = gen_data(VEC[v][31:0] ^ 32'h5555_0000);
      #1;
      check("R3 backward route", bwd_out, bwd_model(w, bwd_in));
    end

    // R10: changing the data alone, with no clock edge, updates the output.
    w = gen_word(32'h8000_0001);
    d = gen_data(32'h3141_5926);
    fwd_in = d;
    #1;
    check("R10 combinational update", fwd_out, fwd_model(w, d));

    // R6: holding sel_load low while sel_addr moves keeps the word.
    w = gen_word(32'hDEAD_BEEF);
    load_cfg(7'd1);
    @(negedge clk);
    sel_addr = 7'd95;
    @(negedge clk);
    @(negedge clk);
    fwd_in = d;
    #1;
    check("R6 hold without load", fwd_out, fwd_model(w, d));

    // R5 and R7: an out-of-range write and an out-of-range load do nothing.
    wa = gen_word(32'h0A0A_0A0A);
    wb = gen_word(32'hB0B0_B0B0);
    write_cfg(7'd4, wa);
    write_cfg(7'd100, wb);
    write_cfg(7'd127, wb);
    load_cfg(7'd4);
    #1;
    check("R5 high write ignored", fwd_out, fwd_model(wa, d));
    load_cfg(7'd100);
    #1;
    check("R7 high load ignored", fwd_out, fwd_model(wa, d));
    load_cfg(7'd96);
    #1;
    check("R7 load at 96 ignored", fwd_out, fwd_model(wa, d));

    // R8: a write and a load at the same edge on the same address.
    wa = gen_word(32'h1111_2222);
    wb = gen_word(32'h3333_4444);
    write_cfg(7'd10, wa);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 7'd10; cfg_wdata = wb;
    sel_load = 1'b1; sel_addr = 7'd10;
    @(negedge clk);
    cfg_we = 1'b0; sel_load = 1'b0;
    #1;
    check("R8 load sees prior word", fwd_out, fwd_model(wa, d));
    load_cfg(7'd10);
    #1;
    check("R8 later load sees new word", fwd_out, fwd_model(wb, d));

    // R1: the messages are only rearranged, with lane j at bits [4j+3:4j].
    d = '0;
    d[3:0] = 4'hF;
    fwd_in = d;
    #1;
    e = '0;
    e[dest_lane(wb, 0)*MSG_W +: MSG_W] = 4'hF;
    check("R1 single lane moves intact", fwd_out, e);

    // R9: a reset in the middle of operation clears the active word again.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    d = gen_data(32'h2718_2818);
    fwd_in = d; bwd_in = d;
    #1;
    check("R9 fwd identity after second reset", fwd_out, d);
    check("R9 bwd identity after second reset", bwd_out, d);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule